// File: doc/BRIEF.md
# PWM Output Emergency-Disable Controller

This block is the output-control slice of a multi-channel timer. It owns two small registers on a simple register bus: an 8-bit output control register and a 6-bit output enable register. The PWM counters and compare logic live elsewhere. This block receives their raw output levels and the current timer mode, and from them drives the final output pins.

In the two PWM modes that support it (complementary and reset-synchronized), the control register can arm an emergency shutdown. A rising edge on the channel-1 capture-A input then clears every output enable bit at once, and all PWM pins drop to their inactive level. Two level-select bits in the same register set the polarity of two output groups, again only in those two modes.

Software restores the outputs by rewriting the enable register. Reset and standby return both registers to their initial values.

Top module: `pwm_kill_ctrl`

## Requirements
- R1: After reset, a read of the control register (address 0) returns 0xFF, and a read of the enable register (address 1) returns 0xFF. Read data is registered and appears one cycle after the address is presented.
- R2: Control register bits 7, 6, 5, 3 and 2 ignore writes and always read as 1.
- R3: Control register bit 4 (trigger off), bit 1 (level select, group B) and bit 0 (level select, group A) are writable and read back as written.
- R4: Enable register bits 5..0 are writable and read back as written. Bits 7..6 always read as 1.
- R5: When bit 4 is 0 and the mode input is 2'b10 (complementary) or 2'b11 (reset-synchronized), a rising edge on the capture-A input clears enable bits 5..0 to 0 at the third rising clock edge after the input rises.
- R6: When bit 4 is 1, a capture-A edge leaves the enable register unchanged.
- R7: In mode 2'b00 or 2'b01, a capture-A edge leaves the enable register unchanged, even when the trigger is armed.
- R8: If a bus write to the enable register lands in the same cycle as a shutdown clear, the clear wins.
- R9: A shutdown clear leaves the control register unchanged. The enable bits stay 0 until software writes them again.
- R10: In modes 2'b10 and 2'b11, pins 2..0 (group A) are inverted when bit 0 is 0 and passed through when it is 1. Pins 5..3 (group B) follow bit 1 in the same way. Each pin is registered one cycle after its inputs.
- R11: In modes 2'b00 and 2'b01, the level-select bits have no effect, and every enabled pin follows its raw input.
- R12: A pin whose enable bit is 0 is driven to 0.
- R13: While standby is high, both registers hold their reset values and bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby request; holds both registers at their reset values |
| mode_i | input | 2 | Timer mode: 00 normal, 01 synchronous, 10 complementary PWM, 11 reset-synchronized PWM |
| capt_a_i | input | 1 | Asynchronous channel-1 capture-A input |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control, 1 enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data for the selected register |
| pwm_raw_i | input | 6 | Raw PWM levels from the compare logic |
| pwm_o | output | 6 | Gated and polarity-adjusted output pins |

## Verification
The bench builds the block with its defaults: six outputs in two groups of three, and a two-stage synchronizer. At this size every write value of both registers can be swept, and the output stage can be checked against all 64 raw input patterns for each mode, each level-select pair and several enable masks. Every mode and arm combination is exercised with a real capture edge. A same-cycle write collision and a standby episode are placed at exact cycles.

// File: rtl/pwm_kill_pkg.sv
package pwm_kill_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SYNC   = 2'b01,
    MODE_COMP   = 2'b10,
    MODE_RSYNC  = 2'b11
  } tmr_mode_e;

  localparam int unsigned REG_W     = 8;
  localparam logic        ADDR_CTRL = 1'b0;
  localparam logic        ADDR_OEN  = 1'b1;

  // Control register bit positions
  localparam int unsigned BIT_TRIG_OFF = 4;
  localparam int unsigned BIT_LVL_A    = 0;
  localparam int unsigned BIT_LVL_B    = 1;

  // True in the two modes where shutdown and polarity apply
  function automatic logic kill_mode(input tmr_mode_e m);
    return (m == MODE_COMP) || (m == MODE_RSYNC);
  endfunction

endpackage

// File: rtl/pwm_kill_sync.sv
module pwm_kill_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign pulse_o = sh_q[STAGES-1] & ~last_q;

  // R5: the trigger is a single-cycle event
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/pwm_kill_regs.sv
module pwm_kill_regs
  import pwm_kill_pkg::*;
#(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               standby_i,
  input  tmr_mode_e          mode_i,
  input  logic               trig_pulse_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [1:0]         lvl_o,
  output logic [NUM_OUT-1:0] oen_o
);
  logic               trig_off_q;
  logic [1:0]         lvl_q;
  logic [NUM_OUT-1:0] oen_q;
  logic [REG_W-1:0]   ctrl_view, oen_view;
  logic               wr_ok, kill;
  logic               unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:NUM_OUT];
  assign wr_ok     = wr_i & ~standby_i;
  assign kill      = trig_pulse_i & ~trig_off_q & kill_mode(mode_i);

  always_ff @(posedge clk) begin
    if (rst || standby_i) begin
      trig_off_q <= 1'b1;
      lvl_q      <= 2'b11;
      oen_q      <= '1;
    end else begin
      if (wr_ok && addr_i == ADDR_CTRL) begin
        trig_off_q <= wdata_i[BIT_TRIG_OFF];
        lvl_q      <= {wdata_i[BIT_LVL_B], wdata_i[BIT_LVL_A]};
      end
      if (kill)
        oen_q <= '0;
      else if (wr_ok && addr_i == ADDR_OEN)
        oen_q <= wdata_i[NUM_OUT-1:0];
    end
  end

  always_comb begin
    ctrl_view               = '1;
    ctrl_view[BIT_TRIG_OFF] = trig_off_q;
    ctrl_view[BIT_LVL_B]    = lvl_q[1];
    ctrl_view[BIT_LVL_A]    = lvl_q[0];
    oen_view                = '1;
    oen_view[NUM_OUT-1:0]   = oen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '1;
    else     rdata_o <= (addr_i == ADDR_CTRL) ? ctrl_view : oen_view;
  end

  assign lvl_o = lvl_q;
  assign oen_o = oen_q;

  // R5 / R8: an armed trigger in a shutdown mode empties the enables, write or not
  a_r5_kill_clears: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse_i && !trig_off_q && kill_mode(mode_i) && !standby_i) |=> (oen_q == '0));

  // R6: a disarmed trigger changes nothing
  a_r6_disarmed_hold: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse_i && trig_off_q && !standby_i && !(wr_i && addr_i == ADDR_OEN))
      |=> $stable(oen_q));

  // R9: a trigger leaves the control register alone
  a_r9_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse_i && !standby_i && !(wr_i && addr_i == ADDR_CTRL))
      |=> ($stable(trig_off_q) && $stable(lvl_q)));

  // R2: reserved control bits read as ones
  a_r2_rsvd_ones: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_i) == ADDR_CTRL) |-> (rdata_o[7:5] == 3'b111 && rdata_o[3:2] == 2'b11));

endmodule

// File: rtl/pwm_kill_outmux.sv
module pwm_kill_outmux
  import pwm_kill_pkg::*;
#(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  tmr_mode_e          mode_i,
  input  logic [1:0]         lvl_i,
  input  logic [NUM_OUT-1:0] oen_i,
  input  logic [NUM_OUT-1:0] raw_i,
  output logic [NUM_OUT-1:0] pwm_o
);
  localparam int unsigned GRP = NUM_OUT / 2;

  logic               pol_active;
  logic [NUM_OUT-1:0] nxt;

  assign pol_active = kill_mode(mode_i);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    localparam int unsigned SEL = (i < GRP) ? 0 : 1;
    assign nxt[i] = oen_i[i] & (raw_i[i] ^ (pol_active & ~lvl_i[SEL]));
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= '0;
    else     pwm_o <= nxt;
  end

  // R12: pins with no enable sit low on the next cycle
  a_r12_gate_low: assert property (@(posedge clk) disable iff (rst)
    (oen_i == '0) |=> (pwm_o == '0));

  // R11: outside the shutdown modes the pins copy enabled raw levels
  a_r11_passthru: assert property (@(posedge clk) disable iff (rst)
    (!pol_active) |=> (pwm_o == $past(raw_i & oen_i)));

endmodule

// File: rtl/pwm_kill_ctrl.sv
module pwm_kill_ctrl
  import pwm_kill_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               standby_i,
  input  logic [1:0]         mode_i,
  input  logic               capt_a_i,
  input  logic               bus_wr_i,
  input  logic               bus_addr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  input  logic [NUM_OUT-1:0] pwm_raw_i,
  output logic [NUM_OUT-1:0] pwm_o
);
  tmr_mode_e          mode;
  logic               trig_pulse;
  logic [1:0]         lvl;
  logic [NUM_OUT-1:0] oen;

  assign mode = tmr_mode_e'(mode_i);

  pwm_kill_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(capt_a_i), .pulse_o(trig_pulse)
  );

  pwm_kill_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst(rst), .standby_i(standby_i), .mode_i(mode),
    .trig_pulse_i(trig_pulse), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .lvl_o(lvl), .oen_o(oen)
  );

  pwm_kill_outmux #(.NUM_OUT(NUM_OUT)) u_out (
    .clk(clk), .rst(rst), .mode_i(mode), .lvl_i(lvl), .oen_i(oen),
    .raw_i(pwm_raw_i), .pwm_o(pwm_o)
  );

endmodule

// File: tb/tb_pwm_kill_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_kill_ctrl;
  logic       clk = 0, rst = 1, standby = 0, capt = 0, wr = 0, addr = 0;
  logic [1:0] mode = 0;
  logic [7:0] wdata = 0, rdata;
  logic [5:0] raw = 0, pwm;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  pwm_kill_ctrl dut (
    .clk(clk), .rst(rst), .standby_i(standby), .mode_i(mode), .capt_a_i(capt),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pwm_raw_i(raw), .pwm_o(pwm)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic fire();
    @(negedge clk); capt = 1;
    repeat (4) @(negedge clk);
    capt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd_reg(0, got); check(got == 8'hFF, "R1 ctrl reset", got, 8'hFF);
    rd_reg(1, got); check(got == 8'hFF, "R1 oen reset", got, 8'hFF);

    // R2 / R3 sweep of control writes
    for (int w = 0; w < 256; w++) begin
      wr_reg(0, 8'(w)); rd_reg(0, got);
      check(got == (8'hEC | (8'(w) & 8'h13)), "R2/R3 ctrl readback", got, 8'hEC | (8'(w) & 8'h13));
    end
    // R4 sweep of enable writes
    for (int w = 0; w < 256; w++) begin
      wr_reg(1, 8'(w)); rd_reg(1, got);
      check(got == (8'hC0 | (8'(w) & 8'h3F)), "R4 oen readback", got, 8'hC0 | (8'(w) & 8'h3F));
    end

    // R5 / R6 / R7 / R9 / R12 trigger in every mode and arm state
    for (int m = 0; m < 4; m++) begin
      for (int arm = 0; arm < 2; arm++) begin
        logic [7:0] pat, expo, expc;
        pat  = 8'h2D ^ 8'(m);
        expc = arm ? 8'hEF : 8'hFF;
        mode = 2'(m);
        wr_reg(0, arm ? 8'h03 : 8'h13);
        wr_reg(1, pat);
        fire();
        rd_reg(1, got);
        if (arm && m >= 2) begin
          expo = 8'hC0;
          check(got == expo, "R5 armed kill clears enables", got, expo);
        end else begin
          expo = 8'hC0 | (pat & 8'h3F);
          check(got == expo, arm ? "R7 trigger outside PWM modes" : "R6 trigger disarmed", got, expo);
        end
        rd_reg(0, got); check(got == expc, "R9 ctrl unchanged by trigger", got, expc);
        repeat (20) @(negedge clk);
        rd_reg(1, got); check(got == expo, "R9 enables stay until written", got, expo);
        wr_reg(1, 8'h3F); rd_reg(1, got); check(got == 8'hFF, "R9 rewrite restores", got, 8'hFF);
      end
    end

    // R8 write colliding with the clear
    mode = 2'b11;
    wr_reg(0, 8'h03); wr_reg(1, 8'h00);
    @(negedge clk); capt = 1;
    @(negedge clk);
    @(negedge clk); wr = 1; addr = 1; wdata = 8'h3F;
    @(negedge clk); wr = 0; capt = 0;
    repeat (3) @(negedge clk);
    rd_reg(1, got); check(got == 8'hC0, "R8 clear beats write", got, 8'hC0);

    // R10 / R11 / R12 output sweep
    for (int m = 0; m < 4; m++) begin
      for (int l = 0; l < 4; l++) begin
        for (int e = 0; e < 3; e++) begin
          logic [5:0] en, flip, exp6;
          en = (e == 0) ? 6'h3F : (e == 1) ? 6'h15 : 6'h2A;
          mode = 2'(m);
          wr_reg(0, 8'h10 | 8'(l));
          wr_reg(1, {2'b00, en});
          flip = (m >= 2) ? {{3{~l[1]}}, {3{~l[0]}}} : 6'h00;
          for (int r = 0; r < 64; r++) begin
            @(negedge clk); raw = 6'(r);
            @(negedge clk);
            exp6 = en & (6'(r) ^ flip);
            check(pwm == exp6, (m >= 2) ? "R10/R12 PWM-mode output" : "R11/R12 pass-through output",
                  pwm, exp6);
          end
        end
      end
    end

    // R13 standby
    wr_reg(0, 8'h00); wr_reg(1, 8'h05);
    @(negedge clk); standby = 1;
    wr_reg(0, 8'h00); wr_reg(1, 8'h00);
    @(negedge clk); standby = 0;
    rd_reg(0, got); check(got == 8'hFF, "R13 ctrl after standby", got, 8'hFF);
    rd_reg(1, got); check(got == 8'hFF, "R13 oen after standby", got, 8'hFF);

    finish_run();
  end
endmodule